// File: doc/BRIEF.md
# Status-Coded Two-Wire Transfer Sequencer

This engine runs one complete master read or write on a two-wire serial bus controller that reports progress through an 8-bit status code and a completion flag. A request names a target (7-bit or 10-bit), a direction and a byte count. The engine then reacts to each raised flag by reading the status code and writing the controller's data and control registers. Outgoing bytes are pulled from a byte source, and incoming bytes are handed to a byte sink. When the transfer ends, the engine raises `done` for one cycle with a result of ok, no device, or I/O error.

Each reaction is chosen from the status code and the bytes still to move. The engine runs a second address phase for 10-bit targets. On a read, it withdraws the acknowledge before the last byte so that the target sees a NACK there. A read of zero bytes works as a presence probe. A flag that arrives while no transfer is running is treated as stale and answered with a stop.

Top module: `twsi_xfer_seq`

## Requirements
- R1: Control words use these bits: bit2 = acknowledge, bit4 = stop, bit5 = start, bit6 = enable, bit7 = interrupt enable. Bit7 is never set. On status 0x08 or 0x10, the engine writes address byte one to the data register together with the control word 0x44. For a 7-bit target, byte one is `{addr[6:0], dir}`, where dir = 1 means read.
- R2: A request accepted while idle writes control 0x64 (start, enable, acknowledge) one cycle later and raises `busy`.
- R3: For a 10-bit target, byte one is `0xF0 | addr[9:8]<<1 | dir`. On status 0x18 or 0x40, the engine writes byte two (`addr[7:0]`) with control 0x44.
- R4: On a write acknowledge, the engine writes the next source byte with control 0x44, pulses `tx_pop`, and decrements the count. A write acknowledge is status 0x18 for a 7-bit target, or status 0xD0 or 0x28. If no bytes remain, it writes stop 0x50 and finishes with ok.
- R5: On read address acknowledge (0x40 for 7-bit, 0xE0 for 10-bit) with bytes requested, the engine writes a continue word. The continue word is 0x44, or 0x40 when exactly one byte is left. On 0x50, the engine delivers the controller's byte on `rx_*` and decrements the count. It writes 0x40 once one byte remains and 0x44 otherwise.
- R6: On 0x58, the engine delivers the final byte, writes stop 0x50, and finishes with ok.
- R7: A read of zero bytes answers the read address acknowledge with stop 0x50 and finishes with ok, delivering no byte.
- R8: Status 0x20, 0x30 or 0x48 writes stop 0x50 and finishes with result 1 (no device).
- R9: Any other status during a transfer writes stop 0x50, pulses `ctl_rst`, and finishes with result 2 (I/O error).
- R10: A flag raised while idle is answered with stop 0x50 and produces no `done`.
- R11: `done` is a one-cycle pulse issued together with the final stop write, and `busy` is low afterwards. Results are 0 = ok, 1 = no device, 2 = I/O error. The flag is ignored for one cycle after each register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start request, taken when idle |
| req_addr | input | 10 | Target address |
| req_ten | input | 1 | 1 = 10-bit target |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Bytes to move |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end pulse |
| result | output | 2 | 0 ok, 1 no device, 2 I/O error |
| tx_data | input | 8 | Next byte to send |
| tx_pop | output | 1 | tx_data was consumed |
| rx_valid | output | 1 | rx_data holds a received byte |
| rx_data | output | 8 | Received byte |
| flag | input | 1 | Controller step complete |
| status | input | 8 | Controller status code |
| rdata | input | 8 | Controller received-data register |
| ctl_we | output | 1 | Control register write strobe |
| ctl_wdata | output | 8 | Control word |
| data_we | output | 1 | Data register write strobe |
| data_wdata | output | 8 | Byte for the data register |
| ctl_rst | output | 1 | Controller reset pulse |

## Verification
The checks assume the controller drops `flag` by the cycle after the write that answers it. They also assume that `status` and `rdata` hold steady while the flag is high. The bench's controller model raises the flag only after the previous answer is seen. It clears the flag on the first cycle that write appears, and leaves idle cycles between steps. The checks further assume that `tx_data` already holds the next byte whenever a write acknowledge can arrive. The bench therefore loads that byte before raising each such status.

// File: rtl/twsi_seq_pkg.sv
package twsi_seq_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;

  // control word bit positions decoded by the controller
  localparam int CB_ACK   = 2;
  localparam int CB_STOP  = 4;
  localparam int CB_START = 5;
  localparam int CB_EN    = 6;
  localparam int CB_IEN   = 7;

  localparam logic [7:0] ST_START      = 8'h08;
  localparam logic [7:0] ST_RSTART     = 8'h10;
  localparam logic [7:0] ST_WADDR_ACK  = 8'h18;
  localparam logic [7:0] ST_WADDR_NAK  = 8'h20;
  localparam logic [7:0] ST_WDATA_ACK  = 8'h28;
  localparam logic [7:0] ST_WDATA_NAK  = 8'h30;
  localparam logic [7:0] ST_RADDR_ACK  = 8'h40;
  localparam logic [7:0] ST_RADDR_NAK  = 8'h48;
  localparam logic [7:0] ST_RDATA_ACK  = 8'h50;
  localparam logic [7:0] ST_RDATA_NAK  = 8'h58;
  localparam logic [7:0] ST_WADDR2_ACK = 8'hD0;
  localparam logic [7:0] ST_RADDR2_ACK = 8'hE0;

  typedef enum logic [3:0] {
    ACT_NONE, ACT_START, ACT_ADDR1, ACT_ADDR2, ACT_SEND,
    ACT_CONT, ACT_RECV, ACT_RECV_STOP, ACT_STOP, ACT_STOP_RST
  } act_e;

  typedef enum logic [1:0] {
    RES_OK = 2'd0, RES_NODEV = 2'd1, RES_IOERR = 2'd2
  } res_e;
endpackage

// File: rtl/twsi_addr_pack.sv
module twsi_addr_pack
  import twsi_seq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              ten,
  input  logic              rd,
  output logic [BYTE_W-1:0] byte_one,
  output logic [BYTE_W-1:0] byte_two
);
  localparam logic [4:0] TEN_PREFIX = 5'b11110;

  always_comb begin
    if (ten) byte_one = {TEN_PREFIX, addr[9:8], rd};
    else     byte_one = {addr[6:0], rd};
    byte_two = addr[7:0];
  end
endmodule

// File: rtl/twsi_status_decode.sv
module twsi_status_decode
  import twsi_seq_pkg::*;
(
  input  logic [7:0] status,
  input  logic       ten,
  input  logic       left_zero,
  input  logic       left_one,
  input  logic       left_two,
  output act_e       act,
  output logic       left_dec,
  output logic       ack_clear,
  output logic       finish,
  output res_e       res
);
  always_comb begin
    act       = ACT_STOP_RST;
    left_dec  = 1'b0;
    ack_clear = 1'b0;
    finish    = 1'b1;
    res       = RES_IOERR;
    case (status)
      ST_START, ST_RSTART: begin
        act    = ACT_ADDR1;
        finish = 1'b0;
      end
      ST_WADDR_ACK, ST_WADDR2_ACK, ST_WDATA_ACK: begin
        if (status == ST_WADDR_ACK && ten) begin
          act    = ACT_ADDR2;
          finish = 1'b0;
        end else if (left_zero) begin
          act = ACT_STOP;
          res = RES_OK;
        end else begin
          act      = ACT_SEND;
          left_dec = 1'b1;
          finish   = 1'b0;
        end
      end
      ST_RADDR_ACK, ST_RADDR2_ACK: begin
        if (status == ST_RADDR_ACK && ten) begin
          act    = ACT_ADDR2;
          finish = 1'b0;
        end else if (left_zero) begin
          act = ACT_STOP;
          res = RES_OK;
        end else begin
          act       = ACT_CONT;
          ack_clear = left_one;
          finish    = 1'b0;
        end
      end
      ST_RDATA_ACK: begin
        act       = ACT_RECV;
        left_dec  = !left_zero;
        ack_clear = left_two || left_one;
        finish    = 1'b0;
      end
      ST_RDATA_NAK: begin
        act = ACT_RECV_STOP;
        res = RES_OK;
      end
      ST_WADDR_NAK, ST_WDATA_NAK, ST_RADDR_NAK: begin
        act = ACT_STOP;
        res = RES_NODEV;
      end
      default: begin
        act = ACT_STOP_RST;
        res = RES_IOERR;
      end
    endcase
  end
endmodule

// File: rtl/twsi_ctl_drive.sv
module twsi_ctl_drive
  import twsi_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic              ack_eff,
  input  logic [BYTE_W-1:0] byte_one,
  input  logic [BYTE_W-1:0] byte_two,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic [BYTE_W-1:0] rdata,
  output logic              ctl_we,
  output logic [BYTE_W-1:0] ctl_wdata,
  output logic              data_we,
  output logic [BYTE_W-1:0] data_wdata,
  output logic              tx_pop,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              ctl_rst
);
  localparam logic [BYTE_W-1:0] W_EN    = BYTE_W'(1) << CB_EN;
  localparam logic [BYTE_W-1:0] W_ACK   = BYTE_W'(1) << CB_ACK;
  localparam logic [BYTE_W-1:0] W_STOP  = W_EN | (BYTE_W'(1) << CB_STOP);
  localparam logic [BYTE_W-1:0] W_START = W_EN | W_ACK | (BYTE_W'(1) << CB_START);

  logic [BYTE_W-1:0] run_word;
  assign run_word = W_EN | (ack_eff ? W_ACK : '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_we     <= 1'b0;
      ctl_wdata  <= '0;
      data_we    <= 1'b0;
      data_wdata <= '0;
      tx_pop     <= 1'b0;
      rx_valid   <= 1'b0;
      rx_data    <= '0;
      ctl_rst    <= 1'b0;
    end else begin
      ctl_we   <= (act != ACT_NONE);
      data_we  <= 1'b0;
      tx_pop   <= 1'b0;
      rx_valid <= 1'b0;
      ctl_rst  <= 1'b0;
      case (act)
        ACT_START: ctl_wdata <= W_START;
        ACT_ADDR1: begin
          data_we    <= 1'b1;
          data_wdata <= byte_one;
          ctl_wdata  <= run_word;
        end
        ACT_ADDR2: begin
          data_we    <= 1'b1;
          data_wdata <= byte_two;
          ctl_wdata  <= run_word;
        end
        ACT_SEND: begin
          data_we    <= 1'b1;
          data_wdata <= tx_data;
          tx_pop     <= 1'b1;
          ctl_wdata  <= run_word;
        end
        ACT_CONT: ctl_wdata <= run_word;
        ACT_RECV: begin
          rx_valid  <= 1'b1;
          rx_data   <= rdata;
          ctl_wdata <= run_word;
        end
        ACT_RECV_STOP: begin
          rx_valid  <= 1'b1;
          rx_data   <= rdata;
          ctl_wdata <= W_STOP;
        end
        ACT_STOP: ctl_wdata <= W_STOP;
        ACT_STOP_RST: begin
          ctl_wdata <= W_STOP;
          ctl_rst   <= 1'b1;
        end
        default: ctl_wdata <= ctl_wdata;
      endcase
    end
  end
endmodule

// File: rtl/twsi_xfer_seq.sv
module twsi_xfer_seq
  import twsi_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [9:0]       req_addr,
  input  logic             req_ten,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result,
  input  logic [7:0]       tx_data,
  output logic             tx_pop,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  input  logic             flag,
  input  logic [7:0]       status,
  input  logic [7:0]       rdata,
  output logic             ctl_we,
  output logic [7:0]       ctl_wdata,
  output logic             data_we,
  output logic [7:0]       data_wdata,
  output logic             ctl_rst
);
  logic [ADDR_W-1:0] addr_q;
  logic              ten_q, rd_q, busy_q, done_q, hold_q, ack_q;
  logic [LEN_W-1:0]  left_q;
  res_e              res_q;

  logic        fire, ack_eff;
  act_e        act, dec_act;
  logic        dec_left_dec, dec_ack_clear, dec_finish;
  res_e        dec_res;
  logic [BYTE_W-1:0] byte_one, byte_two;

  assign fire = flag && !hold_q;

  twsi_addr_pack u_pack (
    .addr(addr_q), .ten(ten_q), .rd(rd_q),
    .byte_one(byte_one), .byte_two(byte_two)
  );

  twsi_status_decode u_dec (
    .status(status), .ten(ten_q),
    .left_zero(left_q == '0),
    .left_one(left_q == LEN_W'(1)),
    .left_two(left_q == LEN_W'(2)),
    .act(dec_act), .left_dec(dec_left_dec), .ack_clear(dec_ack_clear),
    .finish(dec_finish), .res(dec_res)
  );

  always_comb begin
    act = ACT_NONE;
    if (!busy_q) begin
      if (fire)           act = ACT_STOP;
      else if (req_valid) act = ACT_START;
    end else if (fire) begin
      act = dec_act;
    end
    ack_eff = (act == ACT_START) ? 1'b1 : (ack_q && !dec_ack_clear);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ten_q  <= 1'b0;
      rd_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      hold_q <= 1'b0;
      ack_q  <= 1'b1;
      left_q <= '0;
      res_q  <= RES_OK;
    end else begin
      hold_q <= (act != ACT_NONE);
      done_q <= 1'b0;
      if (act == ACT_START) begin
        addr_q <= req_addr;
        ten_q  <= req_ten;
        rd_q   <= req_read;
        left_q <= req_len;
        ack_q  <= 1'b1;
        busy_q <= 1'b1;
      end else if (busy_q && fire) begin
        if (dec_left_dec)  left_q <= left_q - LEN_W'(1);
        if (dec_ack_clear) ack_q  <= 1'b0;
        if (dec_finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= dec_res;
        end
      end
    end
  end

  twsi_ctl_drive u_drv (
    .clk(clk), .rst(rst), .act(act), .ack_eff(ack_eff),
    .byte_one(byte_one), .byte_two(byte_two), .tx_data(tx_data), .rdata(rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .data_we(data_we),
    .data_wdata(data_wdata), .tx_pop(tx_pop), .rx_valid(rx_valid),
    .rx_data(rx_data), .ctl_rst(ctl_rst)
  );

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  done_with_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (ctl_we && ctl_wdata[CB_STOP] && !busy));
  // R2
  start_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[CB_START]) |-> ($past(req_valid) && !$past(busy_q)));
  // R1
  ien_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |-> !ctl_wdata[CB_IEN]);
  // R9
  rst_only_ioerr_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |-> (done && result == RES_IOERR));
  // R4
  pop_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (data_we && !rx_valid));
  // R5
  left_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && $past(busy_q) && $past(left_q) == '0) |-> left_q == '0);
endmodule

// File: tb/twsi_xfer_seq_test.sv
module twsi_xfer_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int KCTL = 0, KDATA = 1, KRX = 2, KDONE = 3, KRST = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [9:0] req_addr = '0;
  logic req_ten = 1'b0, req_read = 1'b0;
  logic [7:0] req_len = '0;
  logic busy, done, tx_pop, rx_valid, ctl_we, data_we, ctl_rst;
  logic [1:0] result;
  logic [7:0] tx_data = '0, rx_data, ctl_wdata, data_wdata;
  logic flag = 1'b0;
  logic [7:0] status = 8'hF8, rdata = '0;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  int kq[$];
  int vq[$];
  string tq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  twsi_xfer_seq #(.LEN_W(8)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_ten(req_ten), .req_read(req_read), .req_len(req_len),
    .busy(busy), .done(done), .result(result), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_valid(rx_valid), .rx_data(rx_data), .flag(flag),
    .status(status), .rdata(rdata), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .ctl_rst(ctl_rst)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int k, input int v, input string tag);
    kq.push_back(k); vq.push_back(v); tq.push_back(tag);
  endtask

  task automatic observe(input int k, input int v);
    if (kq.size() == 0) begin
      chk(1'b0, $sformatf("unexpected kind%0d", k), v, -1);
    end else begin
      int ek = kq.pop_front();
      int ev = vq.pop_front();
      string et = tq.pop_front();
      chk(ek == k && ev == v, et, k * 256 + v, ek * 256 + ev);
    end
  endtask

  // monitor: fixed order rx, data, ctl, rst, done
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) observe(KRX, int'(rx_data));
      if (data_we)  observe(KDATA, int'(data_wdata));
      if (ctl_we)   observe(KCTL, int'(ctl_wdata));
      if (ctl_rst)  observe(KRST, 0);
      if (done)     observe(KDONE, int'(result));
    end
  end

  task automatic request(input logic [9:0] a, input bit ten, input bit rd, input int len);
    expect_ev(KCTL, 8'h64, "R2 start word");
    @(negedge clk);
    req_addr = a; req_ten = ten; req_read = rd; req_len = 8'(len); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy after request", int'(busy), 1);
    @(negedge clk);
  endtask

  task automatic raise(input logic [7:0] st, input logic [7:0] rb);
    @(negedge clk);
    status = st; rdata = rb; flag = 1'b1;
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (ctl_we) break;
    end
    flag = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_idle(input string tag);
    chk(busy == 1'b0, tag, int'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !ctl_we && !data_we, "reset state R11", int'(busy), 0);

    // R10 stale flag while idle
    expect_ev(KCTL, 8'h50, "R10 idle stop");
    raise(8'hF8, 8'h00);
    end_idle("R10 stays idle");

    // R1 R4 7-bit write of two bytes to 0x2A
    request(10'h02A, 1'b0, 1'b0, 2);
    expect_ev(KDATA, 8'h54, "R1 addr byte"); expect_ev(KCTL, 8'h44, "R1 run word");
    raise(8'h08, 8'h00);
    tx_data = 8'hA5;
    expect_ev(KDATA, 8'hA5, "R4 first byte"); expect_ev(KCTL, 8'h44, "R4 word");
    raise(8'h18, 8'h00);
    tx_data = 8'h3C;
    expect_ev(KDATA, 8'h3C, "R4 second byte"); expect_ev(KCTL, 8'h44, "R4 word");
    raise(8'h28, 8'h00);
    expect_ev(KCTL, 8'h50, "R4 stop"); expect_ev(KDONE, 0, "R11 ok");
    raise(8'h28, 8'h00);
    end_idle("R11 idle after write");

    // R5 R6 7-bit read of three bytes from 0x51
    request(10'h051, 1'b0, 1'b1, 3);
    expect_ev(KDATA, 8'hA3, "R1 read addr byte"); expect_ev(KCTL, 8'h44, "R1 word");
    raise(8'h08, 8'h00);
    expect_ev(KCTL, 8'h44, "R5 continue ack");
    raise(8'h40, 8'h00);
    expect_ev(KRX, 8'h11, "R5 byte1"); expect_ev(KCTL, 8'h44, "R5 ack kept");
    raise(8'h50, 8'h11);
    expect_ev(KRX, 8'h22, "R5 byte2"); expect_ev(KCTL, 8'h40, "R5 ack withdrawn");
    raise(8'h50, 8'h22);
    expect_ev(KRX, 8'h33, "R6 last byte"); expect_ev(KCTL, 8'h50, "R6 stop");
    expect_ev(KDONE, 0, "R6 ok");
    raise(8'h58, 8'h33);

    // R5 single-byte read after repeated start
    request(10'h010, 1'b0, 1'b1, 1);
    expect_ev(KDATA, 8'h21, "R1 repeat start addr"); expect_ev(KCTL, 8'h44, "R1 word");
    raise(8'h10, 8'h00);
    expect_ev(KCTL, 8'h40, "R5 single nack word");
    raise(8'h40, 8'h00);
    expect_ev(KRX, 8'h9E, "R6 single byte"); expect_ev(KCTL, 8'h50, "R6 stop");
    expect_ev(KDONE, 0, "R6 ok");
    raise(8'h58, 8'h9E);

    // R7 probe
    request(10'h07F, 1'b0, 1'b1, 0);
    expect_ev(KDATA, 8'hFF, "R7 addr"); expect_ev(KCTL, 8'h44, "R7 word");
    raise(8'h08, 8'h00);
    expect_ev(KCTL, 8'h50, "R7 stop"); expect_ev(KDONE, 0, "R7 ok");
    raise(8'h40, 8'h00);
    end_idle("R7 idle after probe");

    // R3 10-bit write to 0x2B5
    request(10'h2B5, 1'b1, 1'b0, 1);
    expect_ev(KDATA, 8'hF4, "R3 ten byte1"); expect_ev(KCTL, 8'h44, "R3 word");
    raise(8'h08, 8'h00);
    expect_ev(KDATA, 8'hB5, "R3 ten byte2"); expect_ev(KCTL, 8'h44, "R3 word");
    raise(8'h18, 8'h00);
    tx_data = 8'h6E;
    expect_ev(KDATA, 8'h6E, "R4 ten data"); expect_ev(KCTL, 8'h44, "R4 word");
    raise(8'hD0, 8'h00);
    expect_ev(KCTL, 8'h50, "R4 stop"); expect_ev(KDONE, 0, "R4 ok");
    raise(8'h28, 8'h00);

    // R3 10-bit read from 0x1C3
    request(10'h1C3, 1'b1, 1'b1, 1);
    expect_ev(KDATA, 8'hF3, "R3 ten rd byte1"); expect_ev(KCTL, 8'h44, "R3 word");
    raise(8'h08, 8'h00);
    expect_ev(KDATA, 8'hC3, "R3 ten rd byte2"); expect_ev(KCTL, 8'h44, "R3 word");
    raise(8'h40, 8'h00);
    expect_ev(KCTL, 8'h40, "R5 ten nack word");
    raise(8'hE0, 8'h00);
    expect_ev(KRX, 8'h5A, "R6 ten byte"); expect_ev(KCTL, 8'h50, "R6 stop");
    expect_ev(KDONE, 0, "R6 ok");
    raise(8'h58, 8'h5A);

    // R8 address nack on write
    request(10'h033, 1'b0, 1'b0, 2);
    expect_ev(KDATA, 8'h66, "R8 addr"); expect_ev(KCTL, 8'h44, "R8 word");
    raise(8'h08, 8'h00);
    expect_ev(KCTL, 8'h50, "R8 stop"); expect_ev(KDONE, 1, "R8 nodev");
    raise(8'h20, 8'h00);

    // R8 data nack on write
    request(10'h033, 1'b0, 1'b0, 2);
    expect_ev(KDATA, 8'h66, "R8 addr"); expect_ev(KCTL, 8'h44, "R8 word");
    raise(8'h08, 8'h00);
    tx_data = 8'h01;
    expect_ev(KDATA, 8'h01, "R4 data"); expect_ev(KCTL, 8'h44, "R4 word");
    raise(8'h18, 8'h00);
    expect_ev(KCTL, 8'h50, "R8 stop"); expect_ev(KDONE, 1, "R8 nodev data");
    raise(8'h30, 8'h00);

    // R8 read address nack
    request(10'h044, 1'b0, 1'b1, 1);
    expect_ev(KDATA, 8'h89, "R8 rd addr"); expect_ev(KCTL, 8'h44, "R8 word");
    raise(8'h08, 8'h00);
    expect_ev(KCTL, 8'h50, "R8 stop"); expect_ev(KDONE, 1, "R8 nodev read");
    raise(8'h48, 8'h00);

    // R9 unexpected status
    request(10'h044, 1'b0, 1'b1, 2);
    expect_ev(KDATA, 8'h89, "R9 addr"); expect_ev(KCTL, 8'h44, "R9 word");
    raise(8'h08, 8'h00);
    expect_ev(KCTL, 8'h50, "R9 stop"); expect_ev(KRST, 0, "R9 ctl reset");
    expect_ev(KDONE, 2, "R9 ioerr");
    raise(8'h38, 8'h00);
    end_idle("R9 idle after error");

    repeat (4) @(negedge clk);
    chk(kq.size() == 0, "all expected events seen R11", kq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule